// File: doc/BRIEF.md
# Shared-Biased LRU Victim Selector

This block chooses the way to evict from one set of an associative second-level cache bank. It keeps a full least-recently-used order over the ways, a valid bit per way, and a flag per way that tells whether the line is shared by several cores or private to the local core. The flags are driven from outside by coherence logic. Tag lookup and data storage are handled elsewhere.

When a fill is requested, an empty way is taken first. If every way holds a line, the block counts the private lines. If that count reaches a programmable threshold `alpha` (and at least one private line exists), the least recently used private line is evicted. Otherwise the least recently used line of the whole set is evicted, whether or not it is shared. This keeps shared lines resident longer than plain LRU would. Shared lines are worth more because a miss on them delays several cores.

The victim is reported one cycle after the fill request. The chosen way is then the most recently used way, it is valid, and it is marked private.

Top module: `sblru_victim_sel`

## Requirements
- R1: After reset `victim_valid` is 0 and every way is empty (invalid).
- R2: `victim_valid` is 1 in exactly the cycle after a cycle with `fill_req` = 1, with `victim_way` (binary way index) held from that request; it is 0 in every other cycle.
- R3: While any way is empty, a fill picks the empty way with the lowest index, ignoring age and flags.
- R4: A filled way becomes most recently used (age rank 0), valid and private (shared flag 0).
- R5: A touch of way w gives w age rank 0 and raises by one the rank of every way that was more recent than w; all other ranks are unchanged. Rank 0 is most recent and rank WAYS-1 is least recent.
- R6: With all ways valid, if the private count m satisfies m >= alpha and m > 0, the victim is the private way with the highest age rank.
- R7: With all ways valid, if m < alpha or m = 0, the victim is the way with rank WAYS-1, whatever its shared flag.
- R8: alpha = 0 evicts a private line whenever one exists; alpha = WAYS+1 (17) always gives plain LRU.
- R9: A flag update writes `flag_shared` (1 = shared, 0 = private) into way `flag_way`, except when the same cycle's fill targets that way: then the fill's private setting wins.
- R10: A touch that arrives in the same cycle as a fill is ignored.
- R11: The age ranks of all ways always form a permutation of 0..WAYS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | Hit on a way; promote it to most recent |
| touch_way | input | $clog2(WAYS) | Way that was hit |
| flag_valid | input | 1 | Write a shared/private flag |
| flag_way | input | $clog2(WAYS) | Way whose flag is written |
| flag_shared | input | 1 | 1 = shared, 0 = private |
| fill_req | input | 1 | Request a victim and claim it for a fill |
| alpha | input | $clog2(WAYS+2) | Private-count threshold for biasing, 0..WAYS+1 |
| victim_valid | output | 1 | Victim index valid this cycle |
| victim_way | output | $clog2(WAYS) | Way chosen for eviction |

## Verification
The assertions check these rules on every cycle: the ranks stay a permutation, a touched or filled way lands at rank 0, a filled way ends up valid and private, an empty way is taken before any full one, and the selected victim obeys the biased rule or the plain-LRU rule given the current private count and threshold. The bench scenarios show the orderings the assertions cannot pin down. These are the exact index sequence when an empty set fills up, the aging of the other ways after touches, the alpha = 0 and alpha = 17 corners, and the conflicts where a flag write or a touch meets a fill in the same cycle. Each conflict is observed through the victims chosen by later fills.

// File: rtl/sblru_pkg.sv
package sblru_pkg;
   localparam int unsigned SBLRU_WAYS_DEF = 16;

   // threshold must reach WAYS+1 so the bias can be switched off
   function automatic int unsigned thresh_bits(input int unsigned ways);
      return $clog2(ways + 2);
   endfunction
endpackage

// File: rtl/sblru_ranks.sv
module sblru_ranks #(
   parameter int unsigned WAYS = 16,
   parameter int unsigned WW   = $clog2(WAYS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd_valid,
   input  logic [WW-1:0]            upd_way,
   output logic [WAYS-1:0][WW-1:0]  rank_q
);
   logic [WW-1:0] sel_rank;

   always_comb sel_rank = rank_q[upd_way];

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic [WW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= WW'(g);
         end else if (upd_valid) begin
            if (upd_way == WW'(g))
               r_q <= '0;
            else if (r_q < sel_rank)
               r_q <= r_q + 1'b1;
         end
      end
      assign rank_q[g] = r_q;
   end

   // each rank value held by exactly one way
   for (genvar k = 0; k < WAYS; k++) begin : g_perm
      logic [WAYS-1:0] hit;
      always_comb begin
         for (int i = 0; i < WAYS; i++) hit[i] = (rank_q[i] == WW'(k));
      end
      assert_rank_unique_R11: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(hit) == 1);
   end

   assert_promote_mru_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> rank_q[$past(upd_way)] == '0);
endmodule

// File: rtl/sblru_flags.sv
module sblru_flags #(
   parameter int unsigned WAYS = 16,
   parameter int unsigned WW   = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [WW-1:0]    fill_way,
   input  logic             flag_valid,
   input  logic [WW-1:0]    flag_way,
   input  logic             flag_shared,
   output logic [WAYS-1:0]  valid_q,
   output logic [WAYS-1:0]  shared_q
);
   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic v_q, s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
         end else if (fill_en && fill_way == WW'(g)) begin
            v_q <= 1'b1;
            s_q <= 1'b0;
         end else if (flag_valid && flag_way == WW'(g)) begin
            s_q <= flag_shared;
         end
      end
      assign valid_q[g]  = v_q;
      assign shared_q[g] = s_q;
   end

   assert_fill_private_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> valid_q[$past(fill_way)] && !shared_q[$past(fill_way)]);
endmodule

// File: rtl/sblru_pick.sv
module sblru_pick #(
   parameter int unsigned WAYS = 16,
   parameter int unsigned WW   = $clog2(WAYS),
   parameter int unsigned AW   = $clog2(WAYS + 2)
) (
   input  logic [WAYS-1:0][WW-1:0] rank,
   input  logic [WAYS-1:0]         valid,
   input  logic [WAYS-1:0]         shared,
   input  logic [AW-1:0]           alpha,
   output logic [AW-1:0]           priv_cnt,
   output logic [WW-1:0]           victim
);
   logic          any_empty, found_prv, bias;
   logic [WW-1:0] empty_idx, lru_idx, prv_idx, prv_rank;

   always_comb begin
      priv_cnt  = '0;
      empty_idx = '0;
      lru_idx   = '0;
      prv_idx   = '0;
      prv_rank  = '0;
      found_prv = 1'b0;
      any_empty = ~&valid;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!valid[i]) empty_idx = WW'(i);
      end
      for (int i = 0; i < WAYS; i++) begin
         if (!shared[i]) priv_cnt = priv_cnt + AW'(1);
         if (rank[i] == WW'(WAYS - 1)) lru_idx = WW'(i);
         if (!shared[i] && (!found_prv || rank[i] > prv_rank)) begin
            found_prv = 1'b1;
            prv_rank  = rank[i];
            prv_idx   = WW'(i);
         end
      end
      bias = (priv_cnt >= alpha) && found_prv;
      if (any_empty)  victim = empty_idx;
      else if (bias)  victim = prv_idx;
      else            victim = lru_idx;
   end
endmodule

// File: rtl/sblru_victim_sel.sv
module sblru_victim_sel #(
   parameter  int unsigned WAYS = sblru_pkg::SBLRU_WAYS_DEF,
   localparam int unsigned WW   = $clog2(WAYS),
   localparam int unsigned AW   = sblru_pkg::thresh_bits(WAYS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           touch_valid,
   input  logic [WW-1:0]  touch_way,
   input  logic           flag_valid,
   input  logic [WW-1:0]  flag_way,
   input  logic           flag_shared,
   input  logic           fill_req,
   input  logic [AW-1:0]  alpha,
   output logic           victim_valid,
   output logic [WW-1:0]  victim_way
);
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("sblru_victim_sel: WAYS must be a power of two, at least 2");
   end

   logic [WAYS-1:0][WW-1:0] rank_q;
   logic [WAYS-1:0]         valid_q, shared_q;
   logic [AW-1:0]           priv_cnt;
   logic [WW-1:0]           victim_c, upd_way;
   logic                    upd_valid;

   // a fill claims the ordering port; a simultaneous touch is dropped
   assign upd_valid = fill_req | touch_valid;
   assign upd_way   = fill_req ? victim_c : touch_way;

   sblru_ranks #(.WAYS(WAYS), .WW(WW)) u_ranks (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_way(upd_way),
      .rank_q(rank_q));

   sblru_flags #(.WAYS(WAYS), .WW(WW)) u_flags (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_req), .fill_way(victim_c),
      .flag_valid(flag_valid), .flag_way(flag_way), .flag_shared(flag_shared),
      .valid_q(valid_q), .shared_q(shared_q));

   sblru_pick #(.WAYS(WAYS), .WW(WW), .AW(AW)) u_pick (
      .rank(rank_q), .valid(valid_q), .shared(shared_q), .alpha(alpha),
      .priv_cnt(priv_cnt), .victim(victim_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_valid <= 1'b0;
         victim_way   <= '0;
      end else begin
         victim_valid <= fill_req;
         if (fill_req) victim_way <= victim_c;
      end
   end

   assert_empty_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !(&valid_q)) |-> !valid_q[victim_c]);

   assert_biased_private_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && (&valid_q) && priv_cnt >= alpha && priv_cnt != '0)
         |-> !shared_q[victim_c]);

   assert_plain_lru_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && (&valid_q) && (priv_cnt < alpha || priv_cnt == '0))
         |-> rank_q[victim_c] == WW'(WAYS - 1));

   assert_victim_installed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> (rank_q[victim_way] == '0 && valid_q[victim_way]
                        && !shared_q[victim_way]));
endmodule

// File: tb/sblru_victim_sel_bench.sv
module sblru_victim_sel_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WAYS = 16;
   localparam int WW   = 4;
   localparam int AW   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic touch_valid = 1'b0, flag_valid = 1'b0, flag_shared = 1'b0, fill_req = 1'b0;
   logic [WW-1:0] touch_way = '0, flag_way = '0;
   logic [AW-1:0] alpha = AW'(17);
   logic victim_valid;
   logic [WW-1:0] victim_way;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   int m_rank [WAYS];
   bit m_valid [WAYS];
   bit m_shared [WAYS];

   always #(CLK_PERIOD/2) clk = ~clk;

   sblru_victim_sel u_sblru_victim_sel (
      .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_way(touch_way),
      .flag_valid(flag_valid), .flag_way(flag_way), .flag_shared(flag_shared),
      .fill_req(fill_req), .alpha(alpha), .victim_valid(victim_valid),
      .victim_way(victim_way));

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int m_pick(input int a);
      int p = 0, best = -1;
      for (int i = 0; i < WAYS; i++) if (!m_valid[i]) return i;
      for (int i = 0; i < WAYS; i++) if (!m_shared[i]) p++;
      if (p >= a && p > 0) begin
         for (int i = 0; i < WAYS; i++)
            if (!m_shared[i] && (best < 0 || m_rank[i] > m_rank[best])) best = i;
         return best;
      end
      for (int i = 0; i < WAYS; i++) if (m_rank[i] == WAYS - 1) return i;
      return -1;
   endfunction

   function automatic int m_way_at(input int r);
      for (int i = 0; i < WAYS; i++) if (m_rank[i] == r) return i;
      return -1;
   endfunction

   task automatic m_promote(input int w);
      int r = m_rank[w];
      for (int i = 0; i < WAYS; i++) if (m_rank[i] < r) m_rank[i]++;
      m_rank[w] = 0;
   endtask

   // one fill, optionally with a clashing touch or flag write
   task automatic do_fill(input string req, input int a,
                          input bit ten = 0, input int tw = 0,
                          input bit fen = 0, input int fw = 0, input bit fs = 0);
      int exp = m_pick(a);
      @(negedge clk);
      fill_req = 1'b1; alpha = AW'(a);
      touch_valid = ten; touch_way = WW'(tw);
      flag_valid = fen; flag_way = WW'(fw); flag_shared = fs;
      @(negedge clk);
      fill_req = 1'b0; touch_valid = 1'b0; flag_valid = 1'b0;
      check({req, " victim_valid"}, int'(victim_valid), 1);
      check({req, " victim_way"}, int'(victim_way), exp);
      if (fen && fw != exp) m_shared[fw] = fs;
      m_promote(exp);
      m_valid[exp] = 1'b1;
      m_shared[exp] = 1'b0;
   endtask

   task automatic do_touch(input int w);
      @(negedge clk);
      touch_valid = 1'b1; touch_way = WW'(w);
      @(negedge clk);
      touch_valid = 1'b0;
      m_promote(w);
   endtask

   task automatic do_flag(input int w, input bit s);
      @(negedge clk);
      flag_valid = 1'b1; flag_way = WW'(w); flag_shared = s;
      @(negedge clk);
      flag_valid = 1'b0;
      m_shared[w] = s;
   endtask

   task automatic t_reset();
      check("R1 victim_valid after reset", int'(victim_valid), 0);
      @(negedge clk);
      check("R2 idle victim_valid", int'(victim_valid), 0);
   endtask

   task automatic t_fill_empty();
      for (int i = 0; i < WAYS; i++) begin
         check("R3 model lowest empty", m_pick(17), i);
         do_fill("R3 empty fill", 17);
      end
      @(negedge clk);
      check("R2 no victim without fill", int'(victim_valid), 0);
   endtask

   task automatic t_plain_lru();
      do_fill("R7 plain LRU", 17);
      do_touch(1);
      do_touch(2);
      do_fill("R5 touched ways skipped", 17);
      do_touch(m_way_at(5));
      do_fill("R5 aging after touch", 17);
   endtask

   task automatic t_bias();
      for (int w = 4; w < 14; w++) do_flag(w, 1'b1);
      do_fill("R6 m>=alpha private LRU", 6);
      do_fill("R7 m<alpha plain LRU", 9);
      do_fill("R6 m==alpha private LRU", 7);
   endtask

   task automatic t_alpha_corner();
      do_fill("R8 alpha 0 private", 0);
      for (int w = 0; w < WAYS; w++) do_flag(w, 1'b1);
      do_fill("R8 alpha 0 all shared plain LRU", 0);
      do_fill("R8 alpha 17 plain LRU", 17);
   endtask

   task automatic t_flag_clash();
      int v;
      for (int w = 0; w < WAYS; w++) do_flag(w, 1'b1);
      v = m_pick(17);
      do_fill("R9 fill beats flag", 17, 0, 0, 1, v, 1'b1);
      do_fill("R9 filled way stays private", 1);
      v = m_pick(17);
      do_fill("R9 flag to other way applies", 17, 0, 0, 1, (v + 1) % WAYS, 1'b0);
      do_fill("R4 fill sets private", 2);
   endtask

   task automatic t_touch_clash();
      int nxt;
      nxt = m_way_at(WAYS - 2);
      do_fill("R10 fill with touch", 17, 1, nxt);
      do_fill("R10 touch ignored", 17);
   endtask

   initial begin
      for (int i = 0; i < WAYS; i++) begin
         m_rank[i] = i; m_valid[i] = 0; m_shared[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_empty();
      t_plain_lru();
      t_bias();
      t_alpha_corner();
      t_flag_clash();
      t_touch_clash();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule